// File: doc/BRIEF.md
# Gated 8-bit Auto-Reload Timer

This block is a byte-wide up-counter that reloads itself from a second byte register each time it wraps past its top value. On every wrap it raises a sticky overflow flag and, if enabled, an interrupt request. Software programs the count, the reload value and a small control byte through a single-cycle register write port. Software clears the flag through the same port.

Each count step is a tick that comes from one of three sources. The first is every system clock cycle. The second is a single-cycle prescaler enable pulse supplied from outside. The third is a falling edge on an external count pin. Ticks are accepted only while the run bit is set. When gate mode is on, they also need the external gate pin to be low. Both pins are brought into the clock domain through two flip-flops, so the whole block runs on one clock.

Top module: `reload_timer8`

## Requirements
- R1: After a synchronous active-high reset, the count, reload and control registers are zero, and `ovf_flag_o` and `irq_o` are 0.
- R2: A write with `wr_en`=1 takes effect at the next clock edge. Address 0 loads the count, address 1 loads the reload value, and address 2 loads the control byte. Writing address 3 with data bit 0 = 1 clears the overflow flag. Control byte: bit 0 run, bit 1 gate mode, bit 2 external-pin source, bit 3 system-clock source (used when bit 2 is 0, with 0 meaning the prescaler pulse), bit 4 interrupt enable.
- R3: A tick advances the count by exactly one. Ticks are accepted only when run is 1 and either gate mode is 0 or the synchronised gate pin is low. The gate pin passes through two flip-flops, so a change in the pin affects the third clock edge after it.
- R4: A tick while the count is 0xFF loads the count from the reload register and sets the overflow flag at the same edge.
- R5: Counting and reloading never change the reload register. Only a write to address 1 does.
- R6: `irq_o` is 1 exactly when the overflow flag is 1 and the interrupt enable bit is 1.
- R7: The overflow flag stays set until a clear write. If a wrap and a clear happen at the same edge, the flag ends up set.
- R8: A count write at the same edge as a wrap wins over the reload. The flag is still set, and the reload uses the reload value held before that edge.
- R9: With the external-pin source selected, each falling edge of the pin gives one tick. The pin is synchronised through two flip-flops and the edge is detected one stage later. With the prescaler source selected, each cycle in which `presc_tick_i` is 1 gives one tick. With the system-clock source selected, every cycle gives one tick.
- R10: Setting the run bit does not initialise the count. The first period starts from the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| presc_tick_i | input | 1 | Single-cycle prescaler enable pulse |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| gate_pin_i | input | 1 | External gate pin (asynchronous), low allows counting in gate mode |
| cnt_o | output | 8 | Current count |
| reload_o | output | 8 | Current reload value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request, flag masked by enable |

## Verification
The hardest cases to reach are the ones where two events share one clock edge. One is a wrap coinciding with a flag-clear write. The other is a wrap coinciding with a count write. To reach them, the stimulus parks the counter at 0xFF with run off. It then sets run with the system-clock source, and on the very next write cycle it issues the clear or the count write, so the tick and the write meet on a known edge. The pin paths are covered by toggling the count and gate pins across several cycles. The reference model delays them through its own sample history, so the synchroniser latency is checked on every clock.

// File: rtl/rt_pkg.sv
package rt_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_addr_e;

  // packed MSB first: bit 4 down to bit 0
  typedef struct packed {
    logic irq_en;
    logic sys_sel;
    logic ext_sel;
    logic gate_mode;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/rt_sync.sv
module rt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rt_tick_sel.sv
module rt_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic gate_s,
  input  logic presc_tick,
  input  logic run,
  input  logic gate_mode,
  input  logic ext_sel,
  input  logic sys_sel,
  output logic tick
);

  logic pin_prev_q;
  logic pin_fall;
  logic src_tick;
  logic gate_ok;

  always_ff @(posedge clk) begin
    if (rst) pin_prev_q <= 1'b0;
    else     pin_prev_q <= pin_s;
  end

  assign pin_fall = pin_prev_q & ~pin_s;

  always_comb begin
    if (ext_sel)      src_tick = pin_fall;
    else if (sys_sel) src_tick = 1'b1;
    else              src_tick = presc_tick;
  end

  assign gate_ok = ~gate_mode | ~gate_s;
  assign tick    = run & gate_ok & src_tick;

endmodule

// File: rtl/rt_count.sv
module rt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_cnt,
  input  logic         wr_rel,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rel_q,
  output logic         wrap
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign wrap = tick && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wr_data;
    end else if (wrap) begin
      cnt_q <= rel_q;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rel_q <= '0;
    else if (wr_rel) rel_q <= wr_data;
  end

endmodule

// File: rtl/rt_flag.sv
module rt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en_next,
  output logic flag_q,
  output logic irq_q
);

  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en_next;
    end
  end

endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import rt_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              presc_tick_i,
  input  logic              cnt_pin_i,
  input  logic              gate_pin_i,
  output logic [W-1:0]      cnt_o,
  output logic [W-1:0]      reload_o,
  output logic              ovf_flag_o,
  output logic              irq_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  wr_cnt, wr_rel, wr_ctrl, wr_clr;
  logic  pin_s, gate_s;
  logic  tick_w;
  logic  wrap_w;

  assign wr_cnt  = wr_en && (wr_addr == REG_COUNT);
  assign wr_rel  = wr_en && (wr_addr == REG_RELOAD);
  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_clr  = wr_en && (wr_addr == REG_FLAG) && wr_data[0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  rt_sync #(.STAGES(SYNC_STAGES)) u_sync_cnt (
    .clk(clk), .rst(rst), .d(cnt_pin_i), .q(pin_s)
  );

  rt_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
    .clk(clk), .rst(rst), .d(gate_pin_i), .q(gate_s)
  );

  rt_tick_sel u_tick (
    .clk(clk),
    .rst(rst),
    .pin_s(pin_s),
    .gate_s(gate_s),
    .presc_tick(presc_tick_i),
    .run(ctrl_q.run),
    .gate_mode(ctrl_q.gate_mode),
    .ext_sel(ctrl_q.ext_sel),
    .sys_sel(ctrl_q.sys_sel),
    .tick(tick_w)
  );

  rt_count #(.W(W)) u_count (
    .clk(clk),
    .rst(rst),
    .wr_cnt(wr_cnt),
    .wr_rel(wr_rel),
    .wr_data(wr_data),
    .tick(tick_w),
    .cnt_q(cnt_o),
    .rel_q(reload_o),
    .wrap(wrap_w)
  );

  rt_flag u_flag (
    .clk(clk),
    .rst(rst),
    .set(wrap_w),
    .clr(wr_clr),
    .irq_en_next(ctrl_d.irq_en),
    .flag_q(ovf_flag_o),
    .irq_q(irq_o)
  );

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         tick,
  input logic         run,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] reload_o,
  input logic         ovf_flag_o,
  input logic         irq_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic wr_cnt, wr_rel, wr_clr;
  assign wr_cnt = wr_en && (wr_addr == 2'd0);
  assign wr_rel = wr_en && (wr_addr == 2'd1);
  assign wr_clr = wr_en && (wr_addr == 2'd3) && wr_data[0];

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o != TOP && !wr_cnt) |=> cnt_o == W'($past(cnt_o) + 1'b1));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_o == TOP && !wr_cnt) |=> (cnt_o == $past(reload_o)) && ovf_flag_o);

  // R5
  reload_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_rel |=> $stable(reload_o));

  // R6
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ovf_flag_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag_o) |-> $past(wr_clr));

  // R8
  write_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_o == $past(wr_data));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(cnt_o));

endmodule

bind reload_timer8 rt_checker #(.W(W)) u_chk (
  .clk(clk),
  .rst(rst),
  .wr_en(wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .tick(tick_w),
  .run(ctrl_q.run),
  .cnt_o(cnt_o),
  .reload_o(reload_o),
  .ovf_flag_o(ovf_flag_o),
  .irq_o(irq_o)
);

// File: tb/reload_timer8_tb.sv
`timescale 1ns/1ps
module reload_timer8_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       presc_tick_i = 1'b0;
  logic       cnt_pin_i = 1'b1;
  logic       gate_pin_i = 1'b0;
  logic [7:0] cnt_o, reload_o;
  logic       ovf_flag_o, irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reload_timer8 u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .presc_tick_i(presc_tick_i), .cnt_pin_i(cnt_pin_i), .gate_pin_i(gate_pin_i),
    .cnt_o(cnt_o), .reload_o(reload_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  // behavioural reference state
  logic [7:0] m_cnt, m_rel;
  logic m_run, m_gm, m_ext, m_sys, m_ie, m_flag;
  logic p1, p2, p3, g1, g2;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic src, gok, tk, wrap;
    logic [7:0] nc;
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_run = 0; m_gm = 0; m_ext = 0; m_sys = 0; m_ie = 0;
      m_flag = 0; p1 = 0; p2 = 0; p3 = 0; g1 = 0; g2 = 0;
      return;
    end
    src  = m_ext ? (p3 & ~p2) : (m_sys ? 1'b1 : presc_tick_i);
    gok  = !m_gm || !g2;
    tk   = m_run && gok && src;
    wrap = tk && (m_cnt == 8'hFF);
    nc   = m_cnt;
    if (wr_en && wr_addr == 2'd0) nc = wr_data;
    else if (wrap)                nc = m_rel;
    else if (tk)                  nc = m_cnt + 8'd1;
    if (wrap) m_flag = 1'b1;
    else if (wr_en && wr_addr == 2'd3 && wr_data[0]) m_flag = 1'b0;
    if (wr_en && wr_addr == 2'd1) m_rel = wr_data;
    if (wr_en && wr_addr == 2'd2) begin
      m_run = wr_data[0]; m_gm = wr_data[1]; m_ext = wr_data[2];
      m_sys = wr_data[3]; m_ie = wr_data[4];
    end
    m_cnt = nc;
    p3 = p2; p2 = p1; p1 = cnt_pin_i;
    g2 = g1; g1 = gate_pin_i;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R3 count", int'(cnt_o), int'(m_cnt));
    check("R5 reload", int'(reload_o), int'(m_rel));
    check("R7 flag", int'(ovf_flag_o), int'(m_flag));
    check("R6 irq", int'(irq_o), int'(m_flag & m_ie));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 reload", int'(reload_o), 0);
    check("R1 flag", int'(ovf_flag_o), 0);
    check("R1 irq", int'(irq_o), 0);
    cycles(2);

    // R2 R10 writes, no auto-init on run
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hFC);
    wr(2'd2, 8'h09);
    check("R10 cnt kept", int'(cnt_o), 8'hFC);
    check("R2 reload", int'(reload_o), 8'hF0);
    cycles(4);
    // R4 wrap to reload, flag set
    check("R4 cnt", int'(cnt_o), 8'hF0);
    check("R4 flag", int'(ovf_flag_o), 1);
    check("R6 masked", int'(irq_o), 0);
    wr(2'd2, 8'h18);
    check("R6 irq", int'(irq_o), 1);
    check("R5 reload kept", int'(reload_o), 8'hF0);

    // R7 clear
    wr(2'd3, 8'h01);
    check("R7 cleared", int'(ovf_flag_o), 0);
    check("R6 irq drop", int'(irq_o), 0);

    // R7 set wins over clear
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h19);
    wr(2'd3, 8'h01);
    check("R7 set wins", int'(ovf_flag_o), 1);
    check("R4 cnt", int'(cnt_o), 8'hF0);

    // R8 count write wins over reload
    wr(2'd2, 8'h18);
    wr(2'd3, 8'h01);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h19);
    wr(2'd0, 8'h33);
    check("R8 cnt", int'(cnt_o), 8'h33);
    check("R8 flag", int'(ovf_flag_o), 1);

    // R9 prescaler source
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h10);
    for (int i = 0; i < 4; i++) begin
      presc_tick_i = 1'b1; cycle();
      presc_tick_i = 1'b0; cycles(2);
    end
    check("R9 presc", int'(cnt_o), 8'h14);

    // R9 external pin falling edges
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h05);
    for (int i = 0; i < 5; i++) begin
      cnt_pin_i = 1'b0; cycles(3);
      cnt_pin_i = 1'b1; cycles(3);
    end
    cycles(4);
    check("R9 ext", int'(cnt_o), 5);

    // R3 gate pin
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    gate_pin_i = 1'b1;
    cycles(3);
    wr(2'd2, 8'h0B);
    cycles(5);
    check("R3 gated", int'(cnt_o), 8'h80);
    gate_pin_i = 1'b0;
    cycles(7);
    check("R3 ungated", int'(cnt_o), 8'h85);
    cycles(300);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule